// File: doc/BRIEF.md
# Latched Alarm Status Registers with Interrupt

This block holds the alarm status of a line-monitor receiver until a host processor has seen it. Live alarm conditions arrive from detector logic elsewhere. Each one sets a sticky bit in one of several status words; the default is two words of eight bits. The host can poll the words through a single read strobe with a word address. It can also wait for an active-low interrupt that goes low whenever an enabled sticky bit is set.

A normal read returns the addressed word one cycle after the strobe and clears the bits it returned. A burst-mode read, flagged by a qualifier on the strobe, returns the word and clears nothing. A bit whose condition is still present when it is read stays set. A condition that arrives in the same cycle as the read is not in the returned word, but it is captured for the next read. A per-bit enable mask selects which sticky bits can pull the interrupt low.

Top module: `alarm_status_regs`

## Requirements
- R1: While reset is asserted and just after it is released, every sticky bit is 0, `rd_data_o` is 0 and `irq_n_o` is 1.
- R2: A live condition bit that is high for one clock sets its sticky bit. The sticky bit stays 1 until a clearing read, even after the condition drops.
- R3: When `rd_en_i` is high at a clock edge, `rd_data_o` holds the sticky word selected by `rd_addr_i` (0 = first word, 1 = second word) from the next cycle on. Bit i of the word is live input bit `addr*REG_W+i`.
- R4: A read with `rd_burst_i` = 0 clears the sticky bits it returned, so an immediate second read of the same word returns 0.
- R5: A read with `rd_burst_i` = 1 returns the word and leaves every sticky bit unchanged.
- R6: A bit whose live condition is still high during a clearing read stays 1 after that read.
- R7: A condition that rises in the same cycle as a clearing read of its word is not in the returned data, and the next read returns it as 1.
- R8: `irq_n_o` is 0 in the cycle after any sticky bit whose mask bit `irq_mask_i` is 1 becomes set. Sticky bits whose mask bit is 0 never pull it low.
- R9: `irq_n_o` returns to 1 only when every enabled sticky bit has been cleared.
- R10: A clearing read of one word leaves the sticky bits of the other word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| alarm_live_i | input | NUM_REGS*REG_W | Live alarm conditions, word k at bits k*REG_W upward |
| irq_mask_i | input | NUM_REGS*REG_W | Per-bit interrupt enable, 1 = enabled |
| rd_en_i | input | 1 | Host read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Word address of the read |
| rd_burst_i | input | 1 | Burst-mode qualifier, 1 = read without clearing |
| rd_data_o | output | REG_W | Registered read data |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults: two words of eight bits and a one-bit address. At this size the bench can reach every case where the two words interact. These include a clearing read of one word while the other still holds an enabled bit, and masking that covers a whole word. With eight bits per word, the bench can set several bits at once, so a single read is seen to clear only the bits it returned.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int unsigned ALM_NUM_REGS_DEF = 2;
  localparam int unsigned ALM_REG_W_DEF    = 8;

  function automatic int unsigned alm_addr_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/alm_rst_sync.sv
module alm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/alm_latch_bank.sv
module alm_latch_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live_i,
  input  logic         clr_i,
  output logic [W-1:0] lat_o
);
  logic [W-1:0] lat_q;
  logic [W-1:0] lat_d;
  logic [W-1:0] clr_bits;

  // clear only what is set now (and thus returned); a new set always wins
  always_comb begin
    clr_bits = clr_i ? lat_q : '0;
    lat_d    = (lat_q & ~clr_bits) | live_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/alm_read_port.sv
module alm_read_port #(
  parameter int unsigned NUM    = 2,
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_burst_i,
  input  logic [NUM*W-1:0]  lat_flat_i,
  output logic [NUM-1:0]    clr_o,
  output logic [W-1:0]      rd_data_o
);
  logic [W-1:0] sel_word;
  logic [W-1:0] data_q;
  logic [W-1:0] data_d;
  logic         data_en;

  always_comb begin
    sel_word = '0;
    for (int k = 0; k < NUM; k++) begin
      if (rd_addr_i == ADDR_W'(k)) sel_word = lat_flat_i[k*W +: W];
    end
  end

  for (genvar k = 0; k < NUM; k++) begin : g_clr
    assign clr_o[k] = rd_en_i && !rd_burst_i && (rd_addr_i == ADDR_W'(k));
  end

  assign data_en = rd_en_i;
  assign data_d  = sel_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign rd_data_o = data_q;
endmodule

// File: rtl/alm_irq_gen.sv
module alm_irq_gen #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] lat_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_n_o
);
  assign irq_n_o = ~|(lat_i & mask_i);
endmodule

// File: rtl/alarm_status_regs.sv
module alarm_status_regs
  import alm_pkg::*;
#(
  parameter int unsigned NUM_REGS = ALM_NUM_REGS_DEF,
  parameter int unsigned REG_W    = ALM_REG_W_DEF,
  parameter int unsigned ADDR_W   = alm_addr_w(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REGS*REG_W-1:0] alarm_live_i,
  input  logic [NUM_REGS*REG_W-1:0] irq_mask_i,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  input  logic                      rd_burst_i,
  output logic [REG_W-1:0]          rd_data_o,
  output logic                      irq_n_o
);
  localparam int unsigned TOT_W = NUM_REGS * REG_W;

  logic             rst_n_sync;
  logic [TOT_W-1:0] lat_flat;
  logic [NUM_REGS-1:0] clr_sel;

  alm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_bank
    alm_latch_bank #(.W(REG_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .live_i (alarm_live_i[k*REG_W +: REG_W]),
      .clr_i  (clr_sel[k]),
      .lat_o  (lat_flat[k*REG_W +: REG_W])
    );
  end

  alm_read_port #(.NUM(NUM_REGS), .W(REG_W), .ADDR_W(ADDR_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .rd_burst_i (rd_burst_i),
    .lat_flat_i (lat_flat),
    .clr_o      (clr_sel),
    .rd_data_o  (rd_data_o)
  );

  alm_irq_gen #(.N(TOT_W)) u_irq (
    .lat_i   (lat_flat),
    .mask_i  (irq_mask_i),
    .irq_n_o (irq_n_o)
  );
endmodule

// File: rtl/alarm_status_regs_chk.sv
module alarm_status_regs_chk #(
  parameter int unsigned NUM_REGS = 2,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned ADDR_W   = 1
) (
  input logic                      clk,
  input logic                      rst_n_sync,
  input logic [NUM_REGS*REG_W-1:0] lat_flat,
  input logic [NUM_REGS*REG_W-1:0] alarm_live_i,
  input logic [NUM_REGS*REG_W-1:0] irq_mask_i,
  input logic                      rd_en_i,
  input logic [ADDR_W-1:0]         rd_addr_i,
  input logic                      rd_burst_i,
  input logic [REG_W-1:0]          rd_data_o,
  input logic                      irq_n_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n_sync |-> (lat_flat == '0)); // R1

  AST_LIVE_SETS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    1'b1 |=> ((lat_flat & $past(alarm_live_i)) == $past(alarm_live_i))); // R2

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(irq_n_o) |-> $past(|(alarm_live_i & irq_mask_i)) || $past(irq_mask_i) != irq_mask_i); // R8

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(irq_n_o) |-> ($past(rd_en_i) && !$past(rd_burst_i)) || $past(irq_mask_i) != irq_mask_i); // R9

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_sync)
      !(rd_en_i && !rd_burst_i && rd_addr_i == ADDR_W'(k))
      |=> ((lat_flat[k*REG_W +: REG_W] & $past(lat_flat[k*REG_W +: REG_W]))
           == $past(lat_flat[k*REG_W +: REG_W]))); // R10

    AST_BURST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (rd_en_i && rd_burst_i)
      |=> ((lat_flat[k*REG_W +: REG_W] & $past(lat_flat[k*REG_W +: REG_W]))
           == $past(lat_flat[k*REG_W +: REG_W]))); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (rd_en_i && !rd_burst_i && rd_addr_i == ADDR_W'(k))
      |=> ((lat_flat[k*REG_W +: REG_W] & $past(lat_flat[k*REG_W +: REG_W])
            & ~$past(alarm_live_i[k*REG_W +: REG_W])) == '0)); // R4

    AST_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (rd_en_i && rd_addr_i == ADDR_W'(k))
      |=> (rd_data_o == $past(lat_flat[k*REG_W +: REG_W]))); // R3
  end
endmodule

bind alarm_status_regs alarm_status_regs_chk #(
  .NUM_REGS (NUM_REGS),
  .REG_W    (REG_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n_sync   (rst_n_sync),
  .lat_flat     (lat_flat),
  .alarm_live_i (alarm_live_i),
  .irq_mask_i   (irq_mask_i),
  .rd_en_i      (rd_en_i),
  .rd_addr_i    (rd_addr_i),
  .rd_burst_i   (rd_burst_i),
  .rd_data_o    (rd_data_o),
  .irq_n_o      (irq_n_o)
);

// File: tb/alarm_status_regs_tb.sv
module alarm_status_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 2;
  localparam int RW = 8;
  localparam int TW = NR * RW;

  logic          clk;
  logic          rst_n;
  logic [TW-1:0] live;
  logic [TW-1:0] mask;
  logic          rd_en;
  logic          rd_addr;
  logic          rd_burst;
  logic [RW-1:0] rd_data;
  logic          irq_n;

  int n_chk;
  int n_fail;
  bit done;

  alarm_status_regs #(.NUM_REGS(NR), .REG_W(RW), .ADDR_W(1)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .alarm_live_i (live),
    .irq_mask_i   (mask),
    .rd_en_i      (rd_en),
    .rd_addr_i    (rd_addr),
    .rd_burst_i   (rd_burst),
    .rd_data_o    (rd_data),
    .irq_n_o      (irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic a, input logic burst, output logic [RW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; rd_burst = burst;
    @(negedge clk);
    rd_en = 1'b0; rd_burst = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(input logic [TW-1:0] v);
    @(negedge clk);
    live = v;
    @(negedge clk);
    live = '0;
  endtask

  task automatic t_reset();
    logic [RW-1:0] d;
    check("R1 data", 32'(rd_data), 32'h0);
    check("R1 irq", 32'(irq_n), 32'h1);
    do_read(1'b0, 1'b0, d);
    check("R1 word0", 32'(d), 32'h0);
    do_read(1'b1, 1'b0, d);
    check("R1 word1", 32'(d), 32'h0);
  endtask

  task automatic t_latch();
    logic [RW-1:0] d;
    pulse(16'h0005);
    repeat (2) @(negedge clk);
    check("R8 irq low", 32'(irq_n), 32'h0);
    do_read(1'b0, 1'b0, d);
    check("R2 R3 word0", 32'(d), 32'h05);
    check("R9 irq high", 32'(irq_n), 32'h1);
    do_read(1'b0, 1'b0, d);
    check("R4 cleared", 32'(d), 32'h0);
  endtask

  task automatic t_burst();
    logic [RW-1:0] d;
    pulse(16'h8000);
    do_read(1'b1, 1'b1, d);
    check("R5 first burst", 32'(d), 32'h80);
    do_read(1'b1, 1'b1, d);
    check("R5 second burst", 32'(d), 32'h80);
    check("R5 irq kept", 32'(irq_n), 32'h0);
    do_read(1'b1, 1'b0, d);
    check("R4 normal read", 32'(d), 32'h80);
    do_read(1'b1, 1'b0, d);
    check("R4 after clear", 32'(d), 32'h0);
  endtask

  task automatic t_still_active();
    logic [RW-1:0] d;
    @(negedge clk);
    live = 16'h0002;
    do_read(1'b0, 1'b0, d);
    check("R6 first", 32'(d), 32'h02);
    do_read(1'b0, 1'b0, d);
    check("R6 kept while active", 32'(d), 32'h02);
    live = '0;
    do_read(1'b0, 1'b0, d);
    check("R6 last", 32'(d), 32'h02);
    do_read(1'b0, 1'b0, d);
    check("R6 gone", 32'(d), 32'h0);
  endtask

  task automatic t_set_in_read();
    logic [RW-1:0] d;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 1'b0; rd_burst = 1'b0; live = 16'h0008;
    @(negedge clk);
    rd_en = 1'b0; live = '0;
    check("R7 not returned", 32'(rd_data), 32'h0);
    do_read(1'b0, 1'b0, d);
    check("R7 kept", 32'(d), 32'h08);
  endtask

  task automatic t_mask();
    logic [RW-1:0] d;
    mask = 16'h00FF;
    pulse(16'h0100);
    check("R8 masked", 32'(irq_n), 32'h1);
    pulse(16'h0001);
    check("R8 enabled", 32'(irq_n), 32'h0);
    do_read(1'b0, 1'b0, d);
    check("R9 masked left", 32'(irq_n), 32'h1);
    do_read(1'b1, 1'b0, d);
    check("R2 masked bit held", 32'(d), 32'h01);
    mask = 16'hFFFF;
  endtask

  task automatic t_two_regs();
    logic [RW-1:0] d;
    pulse(16'h2010);
    do_read(1'b0, 1'b0, d);
    check("R10 word0", 32'(d), 32'h10);
    check("R9 other word", 32'(irq_n), 32'h0);
    do_read(1'b1, 1'b0, d);
    check("R10 word1 intact", 32'(d), 32'h20);
    check("R9 all clear", 32'(irq_n), 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; live = '0; mask = '1;
    rd_en = 1'b0; rd_addr = 1'b0; rd_burst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'(irq_n), 32'h1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latch();
    t_burst();
    t_still_active();
    t_set_in_read();
    t_mask();
    t_two_regs();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule